// File: doc/BRIEF.md
# SCSI Host DMA Channel Controller

This block is the host-side DMA channel that sits between a SCSI protocol core and host memory. Software programs it through eight word-wide registers. There are three start registers: byte count, memory address and descriptor-list address. The working copies of these three are read-only. A command register holds the operation and the transfer direction. A status register collects completion flags.

Writing the command register with the start operation does three things. It snapshots the start registers into the working registers, clears the status flags and enables the channel. After that, the SCSI core asks for one burst at a time. Each request that matches the programmed direction becomes a single memory request. That request is clamped to the bytes still owed, and the working count and address advance by the granted length. The core signals completion on a separate input, which zeroes the count and raises the done flag.

Status flags are cleared in one of two ways, chosen by an external mode input. In the first, software writes ones to the flags it wants to clear. In the second, reading the status register clears the flags and writes to it are ignored. The status read also carries the live interrupt line of the SCSI core.

Top module: `scsi_dma_chan`

## Requirements
- R1: Reset has four effects. Command, start count, working count and status read as 0. Working address reads 0xFFFFFFFF. Working descriptor address reads 0xFFFFFFFD. The channel is disabled.
- R2: Register indices are 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor address and 7 working descriptor address. A command write whose bits [1:0] equal 3 (start) has two effects. It copies index 1 into 3, index 2 into 4 and index 6 into 7, and it enables the channel.
- R3: A start command clears every stored status flag.
- R4: Command bits [1:0] select the operation. Value 0 (idle) disables the channel, so later bursts are refused. Value 1 (blast) changes neither the enable nor the counters. Value 2 (abort) raises `abort_req` for one cycle in the cycle after the write and leaves the enable unchanged.
- R5: Writes to indices 3, 4 and 7 have no effect.
- R6: A burst request that is granted produces `mem_req` one cycle later. A request is granted when the channel is enabled and `brq_to_mem` equals command bit 7 (1 = device to memory). In the granted request, `mem_addr` is the working address before the burst, `mem_len` is the smaller of the requested length and the working count, and `mem_wr` equals the direction. The working count then falls by `mem_len` and the working address rises by it.
- R7: A burst whose direction differs from command bit 7 produces no `mem_req` and leaves the counters unchanged.
- R8: A `cmd_done` pulse forces the working count to 0 and sets status bit 3 (done).
- R9: Status bit 4 reads as 1 whenever `core_irq` is high, and is not stored.
- R10: With `stat_rd_clears` low, a status write clears only those of bits 1 (error), 2 (abort) and 3 (done) that are written as 1.
- R11: With `stat_rd_clears` high, status writes are ignored. A status read returns the flags and then clears bits 1, 2 and 3.
- R12: A register read presents its data on `reg_rdata` one cycle after `reg_rd`. The command register reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| stat_rd_clears | input | 1 | 1 selects clear-on-read status, 0 selects write-one-to-clear |
| core_irq | input | 1 | SCSI core interrupt line |
| cmd_done | input | 1 | SCSI command completion pulse |
| brq_valid | input | 1 | Burst request from the SCSI side |
| brq_to_mem | input | 1 | Burst direction, 1 = device to memory |
| brq_len | input | 24 | Requested burst length in bytes |
| mem_req | output | 1 | One-cycle memory request |
| mem_wr | output | 1 | Memory request writes memory |
| mem_addr | output | 32 | Memory request byte address |
| mem_len | output | 24 | Memory request byte length |
| dma_en | output | 1 | Channel enabled |
| abort_req | output | 1 | One-cycle cancel request to the SCSI core |

## Verification
Every result in this block is registered and is due exactly one clock edge after its stimulus. This covers a register read, a granted burst's `mem_req` with its address and length, the working registers loaded by a start write, the count cleared by `cmd_done`, and the `abort_req` pulse. The bench drives all inputs just after a falling edge and holds them across one rising edge. It samples the outputs at the next falling edge, so every comparison lands on the first cycle the result is valid. Counter effects are read back through the register port in a separate read.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int unsigned IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IX_CMD  = 3'd0,
    IX_SCNT = 3'd1,
    IX_SADR = 3'd2,
    IX_WCNT = 3'd3,
    IX_WADR = 3'd4,
    IX_STAT = 3'd5,
    IX_SDSC = 3'd6,
    IX_WDSC = 3'd7
  } reg_ix_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } op_e;

  localparam int unsigned CMD_DIR_BIT = 7;

  // status flag positions
  localparam int unsigned ST_PWDN = 0;
  localparam int unsigned ST_ERR  = 1;
  localparam int unsigned ST_ABRT = 2;
  localparam int unsigned ST_DONE = 3;
  localparam int unsigned ST_IRQ  = 4;
  localparam int unsigned ST_BLST = 5;
  localparam int unsigned ST_W    = 6;

  localparam logic [ST_W-1:0] ST_CLR_MASK =
    ST_W'((1 << ST_ERR) | (1 << ST_ABRT) | (1 << ST_DONE));
endpackage

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    cmd_q,
  output logic [DW-1:0]    scnt_q,
  output logic [DW-1:0]    sadr_q,
  output logic [DW-1:0]    sdsc_q,
  output logic             start_p,
  output logic             abort_q,
  output logic             dma_en_q
);
  localparam int unsigned NSTART = 3;

  logic            cmd_wr;
  op_e             op;
  logic [DW-1:0]   start_q [NSTART];

  assign cmd_wr  = wr_en && (wr_idx == IX_CMD);
  assign op      = op_e'(wr_data[1:0]);
  assign start_p = cmd_wr && (op == OP_START);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      dma_en_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      abort_q <= cmd_wr && (op == OP_ABORT);
      if (cmd_wr) begin
        cmd_q <= wr_data;
        case (op)
          OP_IDLE:  dma_en_q <= 1'b0;
          OP_START: dma_en_q <= 1'b1;
          default:  dma_en_q <= dma_en_q;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NSTART; g++) begin : g_start
    localparam logic [IDX_W-1:0] MY_IX =
      (g == 0) ? IX_SCNT : (g == 1) ? IX_SADR : IX_SDSC;
    always_ff @(posedge clk) begin
      if (rst)
        start_q[g] <= '0;
      else if (wr_en && (wr_idx == MY_IX))
        start_q[g] <= wr_data;
    end
  end

  assign scnt_q = start_q[0];
  assign sadr_q = start_q[1];
  assign sdsc_q = start_q[2];
endmodule

// File: rtl/sdma_work.sv
module sdma_work #(
  parameter int unsigned DW    = 32,
  parameter int unsigned LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DW-1:0]    scnt,
  input  logic [DW-1:0]    sadr,
  input  logic [DW-1:0]    sdsc,
  input  logic             cmd_dir,
  input  logic             dma_en,
  input  logic             cmd_done,
  input  logic             brq_valid,
  input  logic             brq_to_mem,
  input  logic [LEN_W-1:0] brq_len,
  output logic [DW-1:0]    wcnt_q,
  output logic [DW-1:0]    wadr_q,
  output logic [DW-1:0]    wdsc_q,
  output logic             mem_req,
  output logic             mem_wr,
  output logic [DW-1:0]    mem_addr,
  output logic [LEN_W-1:0] mem_len
);
  localparam logic [DW-1:0] WADR_RST = '1;
  localparam logic [DW-1:0] WDSC_RST = ~DW'(2);

  logic          accept;
  logic [DW-1:0] len_ext;
  logic [DW-1:0] take;

  assign accept  = brq_valid && dma_en && (brq_to_mem == cmd_dir);
  assign len_ext = DW'(brq_len);
  assign take    = (len_ext > wcnt_q) ? wcnt_q : len_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt_q   <= '0;
      wadr_q   <= WADR_RST;
      wdsc_q   <= WDSC_RST;
      mem_req  <= 1'b0;
      mem_wr   <= 1'b0;
      mem_addr <= '0;
      mem_len  <= '0;
    end else begin
      mem_req <= 1'b0;
      if (load) begin
        wcnt_q <= scnt;
        wadr_q <= sadr;
        wdsc_q <= sdsc;
      end else if (cmd_done) begin
        wcnt_q <= '0;
      end else if (accept) begin
        mem_req  <= 1'b1;
        mem_wr   <= brq_to_mem;
        mem_addr <= wadr_q;
        mem_len  <= take[LEN_W-1:0];
        wcnt_q   <= wcnt_q - take;
        wadr_q   <= wadr_q + take;
      end
    end
  end
endmodule

// File: rtl/sdma_status.sv
module sdma_status
  import sdma_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_all,
  input  logic            set_done,
  input  logic            wr_stat,
  input  logic [ST_W-1:0] wr_bits,
  input  logic            rd_stat,
  input  logic            rd_clears,
  output logic [ST_W-1:0] st_q
);
  logic [ST_W-1:0] st_nxt;

  always_comb begin
    st_nxt = st_q;
    if (clr_all)
      st_nxt = '0;
    else if (rd_clears) begin
      if (rd_stat)
        st_nxt = st_q & ~ST_CLR_MASK;
    end else if (wr_stat) begin
      st_nxt = st_q & ~(wr_bits & ST_CLR_MASK);
    end
    if (set_done)
      st_nxt[ST_DONE] = 1'b1;
    st_nxt[ST_IRQ] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_nxt;
  end
endmodule

// File: rtl/scsi_dma_chan.sv
module scsi_dma_chan
  import sdma_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_idx,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             stat_rd_clears,
  input  logic             core_irq,
  input  logic             cmd_done,
  input  logic             brq_valid,
  input  logic             brq_to_mem,
  input  logic [LEN_W-1:0] brq_len,
  output logic             mem_req,
  output logic             mem_wr,
  output logic [DW-1:0]    mem_addr,
  output logic [LEN_W-1:0] mem_len,
  output logic             dma_en,
  output logic             abort_req
);
  logic [DW-1:0]   cmd_q, scnt_q, sadr_q, sdsc_q;
  logic [DW-1:0]   wcnt_q, wadr_q, wdsc_q;
  logic            start_p;
  logic [ST_W-1:0] stat_q;
  logic [ST_W-1:0] stat_view;

  sdma_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr), .wr_idx(reg_idx), .wr_data(reg_wdata),
    .cmd_q(cmd_q), .scnt_q(scnt_q), .sadr_q(sadr_q), .sdsc_q(sdsc_q),
    .start_p(start_p), .abort_q(abort_req), .dma_en_q(dma_en)
  );

  sdma_work #(.DW(DW), .LEN_W(LEN_W)) u_work (
    .clk(clk), .rst(rst), .load(start_p),
    .scnt(scnt_q), .sadr(sadr_q), .sdsc(sdsc_q),
    .cmd_dir(cmd_q[CMD_DIR_BIT]), .dma_en(dma_en), .cmd_done(cmd_done),
    .brq_valid(brq_valid), .brq_to_mem(brq_to_mem), .brq_len(brq_len),
    .wcnt_q(wcnt_q), .wadr_q(wadr_q), .wdsc_q(wdsc_q),
    .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_len(mem_len)
  );

  sdma_status u_stat (
    .clk(clk), .rst(rst),
    .clr_all(start_p), .set_done(cmd_done),
    .wr_stat(reg_wr && (reg_idx == IX_STAT)), .wr_bits(reg_wdata[ST_W-1:0]),
    .rd_stat(reg_rd && (reg_idx == IX_STAT)), .rd_clears(stat_rd_clears),
    .st_q(stat_q)
  );

  always_comb begin
    stat_view = stat_q;
    stat_view[ST_IRQ] = core_irq;
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_ix_e'(reg_idx))
        IX_CMD:  reg_rdata <= cmd_q;
        IX_SCNT: reg_rdata <= scnt_q;
        IX_SADR: reg_rdata <= sadr_q;
        IX_WCNT: reg_rdata <= wcnt_q;
        IX_WADR: reg_rdata <= wadr_q;
        IX_STAT: reg_rdata <= {{(DW-ST_W){1'b0}}, stat_view};
        IX_SDSC: reg_rdata <= sdsc_q;
        default: reg_rdata <= wdsc_q;
      endcase
    end
  end
endmodule

// File: rtl/scsi_dma_chan_chk.sv
module scsi_dma_chan_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned LEN_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             dma_en,
  input logic             mem_req,
  input logic [DW-1:0]    mem_addr,
  input logic [LEN_W-1:0] mem_len,
  input logic [DW-1:0]    wcnt,
  input logic [DW-1:0]    wadr,
  input logic             cmd_dir,
  input logic             brq_valid,
  input logic             brq_to_mem,
  input logic             cmd_done,
  input logic             start_p,
  input logic             abort_req,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [2:0]       reg_idx,
  input logic [DW-1:0]    reg_wdata,
  input logic             stat_rd_clears,
  input logic [5:0]       stat_q
);
  // R6
  grant_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> $past(dma_en));

  // R6
  len_within_count_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (DW'(mem_len) <= $past(wcnt)));

  // R6
  addr_advance_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (wadr == mem_addr + DW'(mem_len)));

  // R7
  dir_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (brq_valid && (brq_to_mem != cmd_dir)) |=> !mem_req);

  // R8
  done_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && !start_p) |=> (wcnt == '0));

  // R4
  abort_from_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    abort_req |-> $past(reg_wr && (reg_idx == 3'd0) && (reg_wdata[1:0] == 2'd2)));

  // R11
  rdclr_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd_clears && reg_wr && (reg_idx == 3'd5) && !reg_rd && !start_p && !cmd_done)
      |=> $stable(stat_q));
endmodule

bind scsi_dma_chan scsi_dma_chan_chk #(.DW(DW), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .dma_en(dma_en), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_len(mem_len), .wcnt(wcnt_q), .wadr(wadr_q),
  .cmd_dir(cmd_q[7]), .brq_valid(brq_valid), .brq_to_mem(brq_to_mem),
  .cmd_done(cmd_done), .start_p(start_p), .abort_req(abort_req),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
  .stat_rd_clears(stat_rd_clears), .stat_q(stat_q)
);

// File: tb/scsi_dma_chan_tb.sv
module scsi_dma_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 25;
  localparam logic [31:0] NONE = 32'hFFFF_FFFF;

  // kind: 0 write, 1 read and compare, 2 burst (d[31] = to_mem, d[23:0] = len; e = len or NONE)
  typedef struct packed {
    logic [1:0]  k;
    logic [2:0]  ix;
    logic [31:0] d;
    logic [31:0] e;
    logic [7:0]  rq;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd1, 32'd100,       32'd0,       8'd2},  // R2 setup
    '{2'd0, 3'd2, 32'h1000,      32'd0,       8'd2},
    '{2'd0, 3'd6, 32'h2000,      32'd0,       8'd2},
    '{2'd1, 3'd3, 32'd0,         32'd0,       8'd2},  // R2 not loaded yet
    '{2'd0, 3'd0, 32'h83,        32'd0,       8'd2},  // start, to memory
    '{2'd1, 3'd3, 32'd0,         32'd100,     8'd2},  // R2
    '{2'd1, 3'd4, 32'd0,         32'h1000,    8'd2},
    '{2'd1, 3'd7, 32'd0,         32'h2000,    8'd2},
    '{2'd1, 3'd0, 32'd0,         32'h83,      8'd12}, // R12
    '{2'd2, 3'd0, 32'h8000_0028, 32'd40,      8'd6},  // R6
    '{2'd1, 3'd3, 32'd0,         32'd60,      8'd6},
    '{2'd1, 3'd4, 32'd0,         32'h1028,    8'd6},
    '{2'd2, 3'd0, 32'h0000_0004, NONE,        8'd7},  // R7 wrong direction
    '{2'd1, 3'd3, 32'd0,         32'd60,      8'd7},
    '{2'd0, 3'd3, 32'h55,        32'd0,       8'd5},  // R5
    '{2'd0, 3'd4, 32'd0,         32'd0,       8'd5},
    '{2'd1, 3'd3, 32'd0,         32'd60,      8'd5},
    '{2'd1, 3'd4, 32'd0,         32'h1028,    8'd5},
    '{2'd2, 3'd0, 32'h8000_0064, 32'd60,      8'd6},  // R6 clamp
    '{2'd1, 3'd3, 32'd0,         32'd0,       8'd6},
    '{2'd1, 3'd4, 32'd0,         32'h1064,    8'd6},
    '{2'd0, 3'd0, 32'h81,        32'd0,       8'd4},  // R4 blast
    '{2'd1, 3'd3, 32'd0,         32'd0,       8'd4},
    '{2'd0, 3'd0, 32'h80,        32'd0,       8'd4},  // R4 idle
    '{2'd2, 3'd0, 32'h8000_0008, NONE,        8'd4}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        stat_rd_clears = 1'b0, core_irq = 1'b0, cmd_done = 1'b0;
  logic        brq_valid = 1'b0, brq_to_mem = 1'b0;
  logic [23:0] brq_len = '0;
  logic        mem_req, mem_wr, dma_en, abort_req;
  logic [31:0] mem_addr;
  logic [23:0] mem_len;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_dma_chan u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_rd_clears(stat_rd_clears),
    .core_irq(core_irq), .cmd_done(cmd_done), .brq_valid(brq_valid),
    .brq_to_mem(brq_to_mem), .brq_len(brq_len), .mem_req(mem_req), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_len(mem_len), .dma_en(dma_en), .abort_req(abort_req)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] ix, input logic [31:0] d);
    reg_wr = 1'b1; reg_idx = ix; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] ix, output logic [31:0] v);
    reg_rd = 1'b1; reg_idx = ix;
    step();
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic burst(input logic to_mem, input logic [23:0] len);
    brq_valid = 1'b1; brq_to_mem = to_mem; brq_len = len;
    step();
    brq_valid = 1'b0;
  endtask

  task automatic done_pulse();
    cmd_done = 1'b1;
    step();
    cmd_done = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, v); chk("R1 cmd", v, 32'd0);
    rd(3'd3, v); chk("R1 wcnt", v, 32'd0);
    rd(3'd4, v); chk("R1 wadr", v, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R1 stat", v, 32'd0);
    rd(3'd7, v); chk("R1 wdsc", v, 32'hFFFF_FFFD);
    chk("R1 dma_en", {31'd0, dma_en}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].rq, i);
      case (VEC[i].k)
        2'd0: wr(VEC[i].ix, VEC[i].d);
        2'd1: begin rd(VEC[i].ix, v); chk(tag, v, VEC[i].e); end
        default: begin
          burst(VEC[i].d[31], VEC[i].d[23:0]);
          if (VEC[i].e == NONE) chk(tag, {31'd0, mem_req}, 32'd0);
          else begin
            chk(tag, {31'd0, mem_req}, 32'd1);
            chk(tag, {8'd0, mem_len}, VEC[i].e);
          end
        end
      endcase
    end
    chk("R4 idle disables", {31'd0, dma_en}, 32'd0);

    // R6 address and write flag of a burst
    wr(3'd1, 32'd16);
    wr(3'd0, 32'h83);
    burst(1'b1, 24'd4);
    chk("R6 addr", mem_addr, 32'h1000);
    chk("R6 wr", {31'd0, mem_wr}, 32'd1);

    // R4 abort pulse, enable kept
    wr(3'd0, 32'h82);
    chk("R4 abort_req", {31'd0, abort_req}, 32'd1);
    chk("R4 enable kept", {31'd0, dma_en}, 32'd1);
    step();
    chk("R4 abort one cycle", {31'd0, abort_req}, 32'd0);

    // R8 completion
    done_pulse();
    rd(3'd3, v); chk("R8 wcnt", v, 32'd0);
    rd(3'd5, v); chk("R8 done", v, 32'h08);

    // R9 live interrupt bit
    core_irq = 1'b1;
    rd(3'd5, v); chk("R9 irq on", v, 32'h18);
    core_irq = 1'b0;
    rd(3'd5, v); chk("R9 not stored", v, 32'h08);

    // R10 write-one-to-clear
    wr(3'd5, 32'h04);
    rd(3'd5, v); chk("R10 other bit", v, 32'h08);
    wr(3'd5, 32'h08);
    rd(3'd5, v); chk("R10 cleared", v, 32'd0);

    // R11 clear on read
    done_pulse();
    stat_rd_clears = 1'b1;
    wr(3'd5, 32'h08);
    rd(3'd5, v); chk("R11 write ignored", v, 32'h08);
    rd(3'd5, v); chk("R11 read cleared", v, 32'd0);
    stat_rd_clears = 1'b0;

    // R3 start clears status
    done_pulse();
    wr(3'd0, 32'h83);
    rd(3'd5, v); chk("R3 start clears", v, 32'd0);
    rd(3'd3, v); chk("R2 reload", v, 32'd16);

    finished = 1;
    summary();
    $finish;
  end
endmodule